// File: doc/BRIEF.md
# Calibrated RTC Prescaler Chain

This block divides a 32768 Hz low-frequency clock down to a 1 Hz calendar tick. It uses two prescaler stages. The first stage divides by 256 and gives a 128 Hz pulse. The second stage counts those pulses and ticks once per 128 effective counts. All logic runs on the LF clock, and the first-stage pulse acts as a clock enable.

To trim the oscillator, a sign bit and a 6-bit magnitude adjust the second stage during a 64-minute window of 491,520 first-stage pulses. When the sign is clear (slow down), the second stage is stalled on one pulse for each LSB. That adds 256 LF cycles, about -2 ppm per LSB. When the sign is set (speed up), the second stage takes two extra steps for each LSB. That removes 512 LF cycles, about +4 ppm per LSB. The corrections go on the first pulses of each window. Sign and magnitude are captured at a window boundary. Calibration applies only in calendar mode.

A two-bit select drives a calibration clock pin. The pin can be held low, or it can carry a 512 Hz, 256 Hz or 1 Hz square wave, so the trimmed rate can be measured externally.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: The first stage divides the LF clock by 2^PS0_W (256). When uncalibrated, tick_o is a one-cycle pulse once every 2^PS0_W * 2^(PS1_W-1) LF cycles (32768). The first tick after reset release falls on that LF edge count.
- R2: A window is WIN_PULSES first-stage pulses long (491,520 = 64 minutes). Window slots are numbered from 0 at the first pulse of each window.
- R3: With cal_up_i = 0 and magnitude N, the second stage does not advance on window slots 0..N-1. Each LSB delays the later ticks by one first-stage period.
- R4: With cal_up_i = 1 and magnitude N, the second stage advances by two instead of one on window slots 0..2N-1. That gives two extra steps per LSB.
- R5: A double step carries like two normal steps. If it crosses or lands past a 128-count boundary, tick_o fires for that pulse.
- R6: With cal_mode_i = 0 (counter mode), no stall or extra step is applied, whatever the sign and magnitude are.
- R7: A magnitude of 0 produces no adjustment.
- R8: Sign and magnitude are captured on the last pulse of a window and used for the whole next window. After reset the captured magnitude is 0, so the first window is uncorrected.
- R9: out_sel_i selects cal_clk_o as follows: 2'b00 drives low; 2'b01 gives LF/64 (512 Hz); 2'b10 gives LF/128 (256 Hz); 2'b11 gives a 1 Hz square wave. The 1 Hz wave is bit PS1_W-2 of the second-stage count.
- R10: Reset clears both stages and the window counter. During reset, tick_o and cal_clk_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32768 Hz LF clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_mode_i | input | 1 | 1 = calendar mode (calibration on), 0 = counter mode |
| cal_up_i | input | 1 | Correction sign: 1 = speed up, 0 = slow down |
| cal_mag_i | input | 6 | Correction magnitude in LSBs |
| out_sel_i | input | 2 | Calibration clock select |
| tick_o | output | 1 | One-cycle 1 Hz calendar tick |
| cal_clk_o | output | 1 | Calibration clock pin |

## Verification
The bench shrinks the parameters so that one window lasts 1280 clocks. It then records the edge of every tick and checks two things in each window: the first tick and the tick count. An uncorrected run gives the baseline. Slow-down runs with magnitudes of 3 and 63 show the stall moving the first tick later and removing ticks. Speed-up runs with magnitudes of 3 and 63 show the tick arriving earlier and extra ticks appearing. A sequence of slow-down by 1 and then speed-up by 5 leaves the count odd, so one double step jumps over a boundary. The input is changed mid-window, which tests both the carry rule and the boundary capture. Counter mode and a zero magnitude must match the baseline, and each select code is compared against the counting pattern.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  typedef enum logic [1:0] {
    OUT_OFF  = 2'b00,
    OUT_F512 = 2'b01,
    OUT_F256 = 2'b10,
    OUT_F1   = 2'b11
  } clkout_sel_e;
endpackage

// File: rtl/rtc_ps0.sv
module rtc_ps0 #(
  parameter int DIV_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pulse_o,
  output logic f512_o,
  output logic f256_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + DIV_W'(1);
  end

  assign pulse_o = &cnt_q;
  assign f512_o  = cnt_q[DIV_W-3];
  assign f256_o  = cnt_q[DIV_W-2];

  // R1
  pulse_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl #(
  parameter int MAG_W      = 6,
  parameter int WIN_PULSES = 491520
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             cal_mode_i,
  input  logic             cal_up_i,
  input  logic [MAG_W-1:0] cal_mag_i,
  output logic             hold_o,
  output logic             dbl_o
);
  localparam int WIN_W = $clog2(WIN_PULSES);
  localparam int CW    = (WIN_W > MAG_W + 1) ? WIN_W : MAG_W + 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_PULSES - 1);

  logic [WIN_W-1:0] wcnt_q;
  logic             up_q;
  logic [MAG_W-1:0] mag_q;
  logic             win_end;
  logic [CW-1:0]    slot, lim_dn, lim_up;

  assign win_end = pulse_i && (wcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      up_q   <= 1'b0;
      mag_q  <= '0;
    end else if (pulse_i) begin
      wcnt_q <= win_end ? '0 : wcnt_q + WIN_W'(1);
      if (win_end) begin
        up_q  <= cal_up_i;
        mag_q <= cal_mag_i;
      end
    end
  end

  assign slot   = CW'(wcnt_q);
  assign lim_dn = CW'(mag_q);
  assign lim_up = CW'({mag_q, 1'b0});

  assign hold_o = cal_mode_i && pulse_i && !up_q && (slot < lim_dn);
  assign dbl_o  = cal_mode_i && pulse_i &&  up_q && (slot < lim_up);

  // R8
  cal_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(mag_q) && $stable(up_q));

  // R2
  win_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end |=> (wcnt_q == '0));
endmodule

// File: rtl/rtc_ps1.sv
module rtc_ps1 #(
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic hold_i,
  input  logic dbl_i,
  output logic tick_o,
  output logic sec_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, step;
  logic             tick_q;

  always_comb begin
    if (hold_i)     step = '0;
    else if (dbl_i) step = CNT_W'(2);
    else            step = CNT_W'(1);
    cnt_nxt = cnt_q + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      // carry out of the low CNT_W-1 bits: bit CNT_W-2 falls
      tick_q <= pulse_i && cnt_q[CNT_W-2] && !cnt_nxt[CNT_W-2];
      if (pulse_i) cnt_q <= cnt_nxt;
    end
  end

  assign tick_o = tick_q;
  assign sec_o  = cnt_q[CNT_W-2];

  // R3
  hold_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && hold_i) |=> $stable(cnt_q) && !tick_q);

  // R4
  dbl_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && dbl_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(2)));

  // R5
  tick_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tick_q) |-> ($past(cnt_q[CNT_W-2]) && !cnt_q[CNT_W-2]));
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int PS0_W      = 8,
  parameter int PS1_W      = 8,
  parameter int MAG_W      = 6,
  parameter int WIN_PULSES = 491520
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cal_mode_i,
  input  logic             cal_up_i,
  input  logic [MAG_W-1:0] cal_mag_i,
  input  logic [1:0]       out_sel_i,
  output logic             tick_o,
  output logic             cal_clk_o
);
  logic pulse, hold, dbl, f512, f256, sec;

  rtc_ps0 #(.DIV_W(PS0_W)) u_ps0 (
    .clk_i, .rst_ni, .pulse_o(pulse), .f512_o(f512), .f256_o(f256)
  );

  rtc_cal_ctrl #(.MAG_W(MAG_W), .WIN_PULSES(WIN_PULSES)) u_ctrl (
    .clk_i, .rst_ni, .pulse_i(pulse), .cal_mode_i, .cal_up_i, .cal_mag_i,
    .hold_o(hold), .dbl_o(dbl)
  );

  rtc_ps1 #(.CNT_W(PS1_W)) u_ps1 (
    .clk_i, .rst_ni, .pulse_i(pulse), .hold_i(hold), .dbl_i(dbl),
    .tick_o, .sec_o(sec)
  );

  always_comb begin
    unique case (clkout_sel_e'(out_sel_i))
      OUT_F512: cal_clk_o = f512;
      OUT_F256: cal_clk_o = f256;
      OUT_F1:   cal_clk_o = sec;
      default:  cal_clk_o = 1'b0;
    endcase
  end

  // R6
  cnt_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_mode_i |-> !hold && !dbl);
endmodule

// File: tb/rtc_cal_prescaler_test.sv
module rtc_cal_prescaler_test;
  localparam int WIN = 160;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1, up = 1'b0;
  logic [5:0] mag = '0;
  logic [1:0] sel = '0;
  logic       tick, cclk;

  int total = 0, bad = 0, cyc = 0, ntk = 0;
  int tk [0:1023];
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_cal_prescaler #(.PS0_W(3), .PS1_W(4), .MAG_W(6), .WIN_PULSES(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cal_mode_i(mode), .cal_up_i(up),
    .cal_mag_i(mag), .out_sel_i(sel), .tick_o(tick), .cal_clk_o(cclk)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && tick && ntk < 1024) begin tk[ntk] = cyc; ntk++; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic u, input logic [5:0] n);
    rst_n = 1'b0; mode = m; up = u; mag = n; sel = 2'b11;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R10 tick in reset", int'(tick), 0);
    chk(cclk == 1'b0, "R10 clkout in reset", int'(cclk), 0);
    ntk = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_to(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  function automatic int first_tick(input int lo);
    for (int i = 0; i < ntk; i++) if (tk[i] >= lo) return tk[i];
    return -1;
  endfunction

  function automatic int count_ticks(input int lo, input int hi);
    int c = 0;
    for (int i = 0; i < ntk; i++) if (tk[i] >= lo && tk[i] <= hi) c++;
    return c;
  endfunction

  task automatic check_win1(input string req, input int f_exp, input int n_exp);
    wait_to(2570);
    chk(first_tick(1288) == f_exp, {req, " first tick"}, first_tick(1288), f_exp);
    chk(count_ticks(1288, 2560) == n_exp, {req, " tick count"}, count_ticks(1288, 2560), n_exp);
  endtask

  task automatic t_baseline;
    do_reset(1'b1, 1'b0, 6'd0);
    wait_to(1290);
    chk(tk[0] == 64, "R1 first tick", tk[0], 64);
    chk(tk[1] == 128, "R1 tick period", tk[1], 128);
    chk(count_ticks(1, 1280) == 20, "R2 window ticks", count_ticks(1, 1280), 20);
    check_win1("R7 zero mag", 1344, 20);
  endtask

  task automatic t_outsel;
    int e;
    do_reset(1'b0, 1'b0, 6'd0);
    wait_to(100);
    for (int i = 0; i < 16; i++) begin
      e = cyc;
      sel = 2'b00; #1; chk(cclk == 1'b0, "R9 sel off", int'(cclk), 0);
      sel = 2'b01; #1; chk(cclk == e[0], "R9 sel 512", int'(cclk), e & 1);
      sel = 2'b10; #1; chk(cclk == e[1], "R9 sel 256", int'(cclk), (e >> 1) & 1);
      sel = 2'b11; #1; chk(cclk == e[5], "R9 sel 1Hz", int'(cclk), (e >> 5) & 1);
      @(negedge clk);
    end
  endtask

  task automatic t_down;
    do_reset(1'b1, 1'b0, 6'd3);
    wait_to(1285);
    chk(count_ticks(1, 1280) == 20, "R8 first window uncorrected", count_ticks(1, 1280), 20);
    check_win1("R3 down 3", 1368, 19);
    do_reset(1'b1, 1'b0, 6'd63);
    check_win1("R3 down 63", 1848, 12);
  endtask

  task automatic t_up;
    do_reset(1'b1, 1'b1, 6'd3);
    check_win1("R4 up 3", 1312, 20);
    do_reset(1'b1, 1'b1, 6'd63);
    check_win1("R4 up 63", 1312, 35);
  endtask

  task automatic t_carry_latch;
    do_reset(1'b1, 1'b0, 6'd1);
    wait_to(1400);
    up = 1'b1; mag = 6'd5;
    check_win1("R8 mid-window change ignored", 1352, 19);
    wait_to(3850);
    chk(first_tick(2561) == 2568, "R5 double step over boundary", first_tick(2561), 2568);
    chk(count_ticks(2561, 3840) == 22, "R5 window ticks", count_ticks(2561, 3840), 22);
  endtask

  task automatic t_counter_mode;
    do_reset(1'b0, 1'b1, 6'd10);
    check_win1("R6 counter mode up", 1344, 20);
    do_reset(1'b0, 1'b0, 6'd10);
    check_win1("R6 counter mode down", 1344, 20);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_baseline();
    t_outsel();
    t_down();
    t_up();
    t_carry_latch();
    t_counter_mode();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule